// File: doc/BRIEF.md
# Coprocessor Handshake Controller

This block sits on the core side of a coprocessor attachment in which every coprocessor watches the instruction stream and keeps its own copy of the pipeline. When a coprocessor instruction reaches the execute stage, the controller decides whether the core will execute it. If so, it drives an active-low issue strobe. It then reads the absent and busy lines that the coprocessors return. From those lines it completes the instruction, requests an undefined-instruction trap, or holds the pipeline in a busy-wait. An enabled interrupt can end the busy-wait: the controller then gives up the instruction, and the pipeline can run it again after the handler returns.

Each of up to sixteen coprocessors drives its own absent and busy bit, and the block merges them into one shared pair. The merged line reads absent only when every coprocessor reports absent. A busy bit counts only when the same coprocessor is also reporting present, so a busy bit from an absent unit has no effect. The block is a six-state machine with the states idle, issue, wait, done, trap and abort. The issue strobe, the stall and the two requests all come straight from that state and from the merged lines.

Top module: `cp_handshake_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, issue_n is 1 and stall, undef_trap and irq_take are all 0.
- R2: In idle, a cycle with ex_valid=1, cond_pass=1 and in_shadow=0 drives issue_n to 0 in the next cycle.
- R3: An instruction with cond_pass=0 or in_shadow=1 is not issued: issue_n stays 1 and stall, undef_trap and irq_take stay 0 over that cycle and the following one.
- R4: If every cp_absent bit is 1 in the cycle when issue_n is 0 for the first time, undef_trap is 1 for exactly one cycle in the next cycle, with issue_n back at 1 and stall at 0.
- R5: If at least one coprocessor is present and no present coprocessor is busy in the first issue cycle, the instruction completes. issue_n is 0 for that one cycle only, with stall 0 and no trap or interrupt request.
- R6: If a present coprocessor is busy in the first issue cycle, stall is 1 in that same cycle. In every following cycle of the busy-wait, issue_n stays 0 and stall stays 1.
- R7: During the busy-wait, a cycle with no present coprocessor busy and irq_pend=0 ends it. In the next cycle issue_n is 1, stall is 0 and no request is raised.
- R8: During the busy-wait, a cycle with irq_pend=1 abandons the instruction, even if busy drops in that same cycle. In the next cycle irq_take is 1 for exactly one cycle, with issue_n 1 and stall 0.
- R9: irq_pend has no effect outside the busy-wait. An instruction that completes in its issue cycle while irq_pend=1 raises no irq_take.
- R10: A cp_busy bit whose cp_absent bit is 1 is ignored. A coprocessor counts as present when its cp_absent bit is 0.
- R11: After a trap or an abandoned instruction the controller returns to idle and accepts a new (retried) instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ex_valid | input | 1 | A coprocessor instruction is in execute |
| cond_pass | input | 1 | The instruction's condition test passed |
| in_shadow | input | 1 | The instruction sits in a branch shadow |
| irq_pend | input | 1 | An enabled interrupt is pending |
| cp_absent | input | NUM_CP | Per-coprocessor absent (1 = does not accept) |
| cp_busy | input | NUM_CP | Per-coprocessor busy (1 = accepted, not ready) |
| issue_n | output | 1 | Active-low coprocessor issue strobe |
| stall | output | 1 | Hold the instruction stream |
| undef_trap | output | 1 | Request an undefined-instruction trap |
| irq_take | output | 1 | Instruction abandoned; take the interrupt |

## Verification
The bench builds the block with NUM_CP set to 4. This width is small enough to drive by hand, and it still lets one coprocessor be present while others are absent. That makes the masking of busy bits from absent units (R10) visible next to the all-absent trap case. It also covers a single present unit that is busy, idle, or interrupted, including an interrupt that arrives in the same cycle that busy drops.

// File: rtl/cphs_pkg.sv
package cphs_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_ISSUE = 3'd1,
      ST_WAIT  = 3'd2,
      ST_DONE  = 3'd3,
      ST_TRAP  = 3'd4,
      ST_ABORT = 3'd5
   } cphs_state_e;

   localparam int unsigned CPHS_MAX_CP = 16;

endpackage

// File: rtl/cphs_resolve.sv
module cphs_resolve #(
   parameter int unsigned NUM_CP = 16
) (
   input  logic [NUM_CP-1:0] cp_absent,
   input  logic [NUM_CP-1:0] cp_busy,
   output logic              absent_all,
   output logic              busy_any
);

   logic [NUM_CP-1:0] busy_live;

   // only a unit that claims the instruction may hold it busy
   for (genvar g = 0; g < NUM_CP; g++) begin : g_mask
      assign busy_live[g] = cp_busy[g] & ~cp_absent[g];
   end

   assign absent_all = &cp_absent;
   assign busy_any   = |busy_live;

endmodule

// File: rtl/cphs_fsm.sv
module cphs_fsm
   import cphs_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        go,
   input  logic        irq_pend,
   input  logic        absent_all,
   input  logic        busy_any,
   output cphs_state_e state_q
);

   cphs_state_e state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (go) state_d = ST_ISSUE;
         ST_ISSUE: begin
            if (absent_all)    state_d = ST_TRAP;
            else if (busy_any) state_d = ST_WAIT;
            else               state_d = ST_DONE;
         end
         ST_WAIT: begin
            if (irq_pend)       state_d = ST_ABORT;
            else if (!busy_any) state_d = ST_DONE;
         end
         ST_DONE, ST_TRAP, ST_ABORT: state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

endmodule

// File: rtl/cp_handshake_ctrl.sv
module cp_handshake_ctrl
   import cphs_pkg::*;
#(
   parameter int unsigned NUM_CP = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ex_valid,
   input  logic              cond_pass,
   input  logic              in_shadow,
   input  logic              irq_pend,
   input  logic [NUM_CP-1:0] cp_absent,
   input  logic [NUM_CP-1:0] cp_busy,
   output logic              issue_n,
   output logic              stall,
   output logic              undef_trap,
   output logic              irq_take
);

   if (NUM_CP < 1 || NUM_CP > CPHS_MAX_CP) begin : g_bad_cfg
      $error("cp_handshake_ctrl: NUM_CP out of range");
   end

   logic        absent_all;
   logic        busy_any;
   logic        go;
   cphs_state_e state_q;

   assign go = ex_valid & cond_pass & ~in_shadow;

   cphs_resolve #(.NUM_CP(NUM_CP)) u_resolve (
      .cp_absent  (cp_absent),
      .cp_busy    (cp_busy),
      .absent_all (absent_all),
      .busy_any   (busy_any)
   );

   cphs_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .go         (go),
      .irq_pend   (irq_pend),
      .absent_all (absent_all),
      .busy_any   (busy_any),
      .state_q    (state_q)
   );

   assign issue_n    = ~((state_q == ST_ISSUE) | (state_q == ST_WAIT));
   assign stall      = (state_q == ST_WAIT) | ((state_q == ST_ISSUE) & busy_any);
   assign undef_trap = (state_q == ST_TRAP);
   assign irq_take   = (state_q == ST_ABORT);

endmodule

// File: rtl/cphs_chk.sv
module cphs_chk
   import cphs_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        ex_valid,
   input logic        cond_pass,
   input logic        in_shadow,
   input logic        irq_pend,
   input logic        absent_all,
   input logic        busy_any,
   input cphs_state_e state_q,
   input logic        issue_n,
   input logic        stall,
   input logic        undef_trap,
   input logic        irq_take
);

   a_r1_outputs_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({undef_trap, irq_take, ~issue_n}));

   a_r3_no_issue_unqualified: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_n && !(ex_valid && cond_pass && !in_shadow)) |=> issue_n);

   a_r4_trap_on_absent: assert property (@(posedge clk) disable iff (!rst_n)
      (!issue_n && !stall && absent_all) |=> undef_trap);

   a_r4_trap_single: assert property (@(posedge clk) disable iff (!rst_n)
      undef_trap |=> (!undef_trap && issue_n));

   a_r6_stall_holds_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> !issue_n);

   a_r8_irq_breaks_wait: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT && irq_pend) |=> (irq_take && !stall));

   a_r8_take_single: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take |=> !irq_take);

endmodule

bind cp_handshake_ctrl cphs_chk u_cphs_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ex_valid   (ex_valid),
   .cond_pass  (cond_pass),
   .in_shadow  (in_shadow),
   .irq_pend   (irq_pend),
   .absent_all (absent_all),
   .busy_any   (busy_any),
   .state_q    (state_q),
   .issue_n    (issue_n),
   .stall      (stall),
   .undef_trap (undef_trap),
   .irq_take   (irq_take)
);

// File: tb/test_cp_handshake_ctrl.sv
module test_cp_handshake_ctrl;

   localparam int unsigned NCP = 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           ex_valid = 1'b0, cond_pass = 1'b0, in_shadow = 1'b0, irq_pend = 1'b0;
   logic [NCP-1:0] cp_absent = '1, cp_busy = '0;
   logic           issue_n, stall, undef_trap, irq_take;

   typedef struct {
      logic [3:0] outs;   // {issue_n, stall, undef_trap, irq_take}
      string      tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_run = 0, n_fail = 0;
   bit   finished = 0;

   localparam logic [NCP-1:0] ALL_ABS = 4'b1111;
   localparam logic [NCP-1:0] CP0_ON  = 4'b1110;

   always #10 clk = ~clk;

   cp_handshake_ctrl #(.NUM_CP(NCP)) i_cp_handshake_ctrl (
      .clk(clk), .rst_n(rst_n), .ex_valid(ex_valid), .cond_pass(cond_pass),
      .in_shadow(in_shadow), .irq_pend(irq_pend), .cp_absent(cp_absent),
      .cp_busy(cp_busy), .issue_n(issue_n), .stall(stall),
      .undef_trap(undef_trap), .irq_take(irq_take)
   );

   task automatic check_now(input logic [3:0] e, input string tag);
      n_run++;
      if ({issue_n, stall, undef_trap, irq_take} !== e) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b", tag,
                  {issue_n, stall, undef_trap, irq_take}, e);
      end
   endtask

   // driver: set this cycle's inputs, queue the outputs expected in it
   task automatic step(input logic ex, input logic cp, input logic sh, input logic irq,
                       input logic [NCP-1:0] ab, input logic [NCP-1:0] bz,
                       input logic [3:0] e, input string tag);
      exp_t it;
      @(negedge clk);
      ex_valid = ex; cond_pass = cp; in_shadow = sh; irq_pend = irq;
      cp_absent = ab; cp_busy = bz;
      it.outs = e; it.tag = tag;
      exp_q.push_back(it);
   endtask

   task automatic idle(input logic [3:0] e, input string tag);
      step(0, 0, 0, 0, ALL_ABS, '0, e, tag);
   endtask

   task automatic launch(input string tag);
      step(1, 1, 0, 0, ALL_ABS, '0, 4'b1000, tag);
   endtask

   // monitor: compare away from the clock edge
   initial begin
      forever begin
         @(negedge clk);
         #5;
         if (exp_q.size() > 0) begin
            exp_t it;
            it = exp_q.pop_front();
            check_now(it.outs, it.tag);
         end
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: got hang expected finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #5 check_now(4'b1000, "R1 during reset");
      rst_n = 1'b1;
      idle(4'b1000, "R1 after reset");

      // R2 and R5: clean completion
      launch("R2 launch");
      step(0, 0, 0, 0, CP0_ON, '0, 4'b0000, "R2 R5 issue cycle");
      idle(4'b1000, "R5 strobe released");
      idle(4'b1000, "R5 idle again");

      // R4: nobody claims it
      launch("R4 launch");
      step(0, 0, 0, 0, ALL_ABS, '0, 4'b0000, "R4 issue");
      idle(4'b1010, "R4 trap");
      idle(4'b1000, "R4 trap single cycle");

      // R11: fresh instruction after trap
      launch("R11 launch after trap");
      step(0, 0, 0, 0, CP0_ON, '0, 4'b0000, "R11 issue after trap");
      idle(4'b1000, "R11 done");

      // R6 and R7: busy-wait then release
      launch("R6 launch");
      step(0, 0, 0, 0, CP0_ON, 4'b0001, 4'b0100, "R6 stall in issue");
      step(0, 0, 0, 0, CP0_ON, 4'b0001, 4'b0100, "R6 wait");
      step(0, 0, 0, 0, CP0_ON, 4'b0000, 4'b0100, "R6 wait last");
      idle(4'b1000, "R7 released");
      idle(4'b1000, "R7 idle");

      // R8: interrupt during busy-wait, then R11 retry
      launch("R8 launch");
      step(0, 0, 0, 0, CP0_ON, 4'b0001, 4'b0100, "R8 stall");
      step(0, 0, 0, 1, CP0_ON, 4'b0001, 4'b0100, "R8 wait irq");
      idle(4'b1001, "R8 take");
      idle(4'b1000, "R8 take single cycle");
      launch("R11 retry launch");
      step(0, 0, 0, 0, CP0_ON, '0, 4'b0000, "R11 retry issue");
      idle(4'b1000, "R11 retry done");

      // R8: interrupt beats busy dropping
      launch("R8 prio launch");
      step(0, 0, 0, 0, CP0_ON, 4'b0001, 4'b0100, "R8 prio stall");
      step(0, 0, 0, 1, CP0_ON, 4'b0000, 4'b0100, "R8 prio wait");
      idle(4'b1001, "R8 prio take");
      idle(4'b1000, "R8 prio idle");

      // R3: condition fail and branch shadow
      step(1, 0, 0, 0, ALL_ABS, '0, 4'b1000, "R3 cond fail");
      idle(4'b1000, "R3 cond fail not issued");
      step(1, 1, 1, 0, ALL_ABS, '0, 4'b1000, "R3 shadow");
      idle(4'b1000, "R3 shadow not issued");

      // R9: interrupt outside busy-wait
      step(1, 1, 0, 1, ALL_ABS, '0, 4'b1000, "R9 launch with irq");
      step(0, 0, 0, 1, CP0_ON, '0, 4'b0000, "R9 issue with irq");
      step(0, 0, 0, 1, ALL_ABS, '0, 4'b1000, "R9 done without take");
      idle(4'b1000, "R9 idle");

      // R10: busy from an absent unit
      launch("R10 launch");
      step(0, 0, 0, 0, CP0_ON, 4'b0010, 4'b0000, "R10 absent busy ignored");
      idle(4'b1000, "R10 completes");
      launch("R10 launch all absent");
      step(0, 0, 0, 0, ALL_ABS, 4'b1111, 4'b0000, "R10 busy masked when absent");
      idle(4'b1010, "R10 trap");
      idle(4'b1000, "R10 idle");

      @(negedge clk);
      #8;
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule